// File: doc/BRIEF.md
# Full/Empty Synchronizing Word Access Unit

This unit stands between a processor's load/store port and a small word store. Every word holds a 32-bit data value plus one synchronization bit that marks the word full or empty. Each request carries an access code from 1 to 8. The code selects one of eight load behaviours or one of eight store behaviours. For a given access, the code decides three things: whether the synchronization bit is rewritten, whether meeting the wrong bit state raises a synchronization trap, and whether a cache miss traps or stalls the processor.

Requests enter on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while the unit stalls on a miss. A requester that sees `req_ready` low must hold its request steady until it is taken. Each accepted request ends in exactly one result pulse: a completion, a synchronization trap, or a miss trap. The result has no ready input; the processor side must take it in the cycle it appears. A condition output reports the synchronization bit that each access found, for use by branch-on-full and branch-on-empty instructions.

Top module: `fesync_unit`

## Requirements
- R1: After reset, every word holds data 0 and is empty. `req_ready` is 1, and `hold`, `rsp_valid`, `trap_sync`, `trap_miss` and `cond_full` are all 0.
- R2: The access code is `req_code` = code−1. Bit 2 = 1 stalls on a miss, and bit 2 = 0 traps on a miss. Bit 1 = 1 never raises a synchronization trap. Bit 0 = 1 rewrites the synchronization bit: a load leaves the word empty, and a store leaves it full.
- R3: A load whose code bit 1 is 0 that finds the word empty, or a store whose code bit 1 is 0 that finds the word full, pulses `trap_sync`. It leaves both the data and the synchronization bit of the word unchanged.
- R4: Any other load pulses `rsp_valid` with the word's data on `rsp_rdata`. If code bit 0 is 1, the word is left empty.
- R5: Any other store writes `req_wdata` into the word and pulses `rsp_valid`. If code bit 0 is 1, the word is left full; otherwise its bit is unchanged.
- R6: Every access that reaches the word, including one that raises a synchronization trap, sets `cond_full` to the synchronization bit the word held before that access (1 = full).
- R7: A request taken with `miss` high and code bit 2 = 0 pulses `trap_miss` one cycle later. It changes no word and leaves `cond_full` unchanged.
- R8: A request taken with `miss` high and code bit 2 = 1 raises `hold` from the next cycle, and `req_ready` is 0 while `hold` is 1. The hold lasts until `fill_done` pulses. On the edge where `fill_done` is seen, the stalled access completes as in R3–R6, and `hold` drops.
- R9: A request taken without a miss shows its result in the cycle after acceptance. A request taken in the very next cycle sees the word as the previous request left it.
- R10: At most one of `rsp_valid`, `trap_sync` and `trap_miss` is high in any cycle, and each accepted request produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_code | input | 3 | Access code minus one (see R2) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| miss | input | 1 | The offered access misses the cache |
| fill_done | input | 1 | One-cycle pulse: the missing data has arrived |
| hold | output | 1 | Processor stalled on a miss |
| rsp_valid | output | 1 | Access completed |
| rsp_rdata | output | DATA_W | Load data, valid with `rsp_valid` on a load |
| trap_sync | output | 1 | Synchronization trap pulse |
| trap_miss | output | 1 | Miss trap pulse |
| cond_full | output | 1 | Synchronization bit found by the latest access |

## Verification
The properties assume three things about the inputs. `fill_done` pulses only while `hold` is high. `miss` matters only on a cycle where a request is taken. A requester never expects a result while `hold` is high. The stimulus keeps to these assumptions: it raises `fill_done` for a single cycle, a few cycles into each stall, and lowers `req_valid` after each request is taken. It also runs every code in both directions against words in both states, so each outcome of the trap/modify/miss decision is reached.

// File: rtl/fesync_pkg.sv
package fesync_pkg;
  localparam int CODE_W = 3;

  // Behaviour picked by one access code
  typedef struct packed {
    logic stall_on_miss;  // 1: hold until fill, 0: trap on miss
    logic never_trap;     // 1: mismatch does not trap
    logic rewrite_bit;    // 1: load empties / store fills
  } fe_ctl_t;
endpackage

// File: rtl/fesync_decode.sv
module fesync_decode
  import fesync_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output fe_ctl_t           ctl_o
);
  always_comb begin
    ctl_o.stall_on_miss = code_i[2];
    ctl_o.never_trap    = code_i[1];
    ctl_o.rewrite_bit   = code_i[0];
  end
endmodule

// File: rtl/fesync_eval.sv
module fesync_eval
  import fesync_pkg::*;
(
  input  logic    is_store_i,
  input  fe_ctl_t ctl_i,
  input  logic    full_i,
  output logic    sync_trap_o,
  output logic    upd_o,
  output logic    wr_data_o,
  output logic    new_full_o
);
  logic mismatch;

  always_comb begin
    mismatch    = is_store_i ? full_i : ~full_i;
    sync_trap_o = mismatch & ~ctl_i.never_trap;
    upd_o       = ~sync_trap_o;
    wr_data_o   = is_store_i & ~sync_trap_o;
    new_full_o  = ctl_i.rewrite_bit ? is_store_i : full_i;
  end
endmodule

// File: rtl/fesync_words.sv
module fesync_words #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rfull_o,
  input  logic              upd_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              new_full_i
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  full_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic sel;
    assign sel = (addr_i == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        full_q[g] <= 1'b0;
      end else if (sel && upd_i) begin
        if (wr_data_i) data_q[g] <= wdata_i;
        full_q[g] <= new_full_i;
      end
    end
  end

  assign rdata_o = data_q[addr_i];
  assign rfull_o = full_q[addr_i];
endmodule

// File: rtl/fesync_unit.sv
module fesync_unit
  import fesync_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [2:0]        req_code,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              miss,
  input  logic              fill_done,
  output logic              hold,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              trap_sync,
  output logic              trap_miss,
  output logic              cond_full
);
  // Stalled request
  logic              stall_q;
  logic              p_store_q;
  logic [2:0]        p_code_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_wdata_q;

  // Request being executed this cycle
  logic              x_store;
  logic [2:0]        x_code;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] x_wdata;

  fe_ctl_t           live_ctl, x_ctl;
  logic              accept, fire, miss_trap, start_stall;
  logic              sync_trap, upd, wr_data, new_full;
  logic [DATA_W-1:0] word_data;
  logic              word_full;

  assign req_ready = ~stall_q;
  assign hold      = stall_q;
  assign accept    = req_valid & req_ready;

  fesync_decode u_dec_live (.code_i(req_code), .ctl_o(live_ctl));

  assign miss_trap   = accept & miss & ~live_ctl.stall_on_miss;
  assign start_stall = accept & miss &  live_ctl.stall_on_miss;
  assign fire        = (accept & ~miss) | (stall_q & fill_done);

  always_comb begin
    if (stall_q) begin
      x_store = p_store_q;
      x_code  = p_code_q;
      x_addr  = p_addr_q;
      x_wdata = p_wdata_q;
    end else begin
      x_store = req_store;
      x_code  = req_code;
      x_addr  = req_addr;
      x_wdata = req_wdata;
    end
  end

  fesync_decode u_dec_exec (.code_i(x_code), .ctl_o(x_ctl));

  fesync_words #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_words (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (x_addr),
    .rdata_o    (word_data),
    .rfull_o    (word_full),
    .upd_i      (fire & upd),
    .wr_data_i  (wr_data),
    .wdata_i    (x_wdata),
    .new_full_i (new_full)
  );

  fesync_eval u_eval (
    .is_store_i  (x_store),
    .ctl_i       (x_ctl),
    .full_i      (word_full),
    .sync_trap_o (sync_trap),
    .upd_o       (upd),
    .wr_data_o   (wr_data),
    .new_full_o  (new_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q   <= 1'b0;
      p_store_q <= 1'b0;
      p_code_q  <= '0;
      p_addr_q  <= '0;
      p_wdata_q <= '0;
    end else if (start_stall) begin
      stall_q   <= 1'b1;
      p_store_q <= req_store;
      p_code_q  <= req_code;
      p_addr_q  <= req_addr;
      p_wdata_q <= req_wdata;
    end else if (stall_q && fill_done) begin
      stall_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      trap_sync <= 1'b0;
      trap_miss <= 1'b0;
      cond_full <= 1'b0;
    end else begin
      rsp_valid <= fire & ~sync_trap;
      trap_sync <= fire &  sync_trap;
      trap_miss <= miss_trap;
      if (fire) begin
        cond_full <= word_full;
        if (!x_store && !sync_trap) rsp_rdata <= word_data;
      end
    end
  end
endmodule

// File: rtl/fesync_checks.sv
module fesync_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_code,
  input logic       miss,
  input logic       fill_done,
  input logic       hold,
  input logic       rsp_valid,
  input logic       trap_sync,
  input logic       trap_miss
);
  logic accept;
  assign accept = req_valid & req_ready;

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, trap_sync, trap_miss}));

  a_r8_no_ready_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !req_ready);

  a_r8_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !fill_done |=> hold);

  a_r8_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
    hold && fill_done |=> !hold && (rsp_valid || trap_sync));

  a_r8_stall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept && miss && req_code[2] |=> hold && !rsp_valid && !trap_sync && !trap_miss);

  a_r7_miss_trap: assert property (@(posedge clk) disable iff (!rst_n)
    accept && miss && !req_code[2] |=> trap_miss && !hold);

  a_r9_next_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !miss |=> (rsp_valid || trap_sync) && !trap_miss);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !(hold && fill_done) |=> !rsp_valid && !trap_sync && !trap_miss);
endmodule

bind fesync_unit fesync_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_code  (req_code),
  .miss      (miss),
  .fill_done (fill_done),
  .hold      (hold),
  .rsp_valid (rsp_valid),
  .trap_sync (trap_sync),
  .trap_miss (trap_miss)
);

// File: tb/fesync_unit_test.sv
module fesync_unit_test;
  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_store = 1'b0, miss = 1'b0, fill_done = 1'b0;
  logic [2:0]    req_code = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, hold, rsp_valid, trap_sync, trap_miss, cond_full;
  logic [DW-1:0] rsp_rdata;

  always #4 clk = ~clk;

  fesync_unit #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_code(req_code), .req_addr(req_addr),
    .req_wdata(req_wdata), .miss(miss), .fill_done(fill_done), .hold(hold),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .trap_sync(trap_sync),
    .trap_miss(trap_miss), .cond_full(cond_full)
  );

  typedef struct {
    int          kind;   // 0 completion, 1 sync trap, 2 miss trap
    logic [DW-1:0] rdata;
    logic        chk_data;
    logic        cond;
    string       req;
  } exp_t;

  exp_t          sb[$];
  int            checks = 0, fails = 0;
  logic [DW-1:0] m_data [DEPTH];
  logic          m_full [DEPTH];
  logic          m_cond = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (rsp_valid || trap_sync || trap_miss)) begin
      int k;
      k = rsp_valid ? 0 : (trap_sync ? 1 : 2);
      if (sb.size() == 0) begin
        check(1'b0, "R10", "unexpected outcome", k, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(k == e.kind, e.req, "outcome kind", k, e.kind);
        check(cond_full == e.cond, "R6", "cond_full", cond_full, e.cond);
        if (e.chk_data) check(rsp_rdata == e.rdata, e.req, "load data", rsp_rdata, e.rdata);
      end
    end
  end

  // Driver: model from requirements, push expectation, drive request
  task automatic access(input bit st, input int code, input int addr,
                        input logic [DW-1:0] wd, input bit mis, input int delay);
    exp_t e;
    logic [2:0] c;
    bit trap_now;
    c = 3'(code - 1);
    e.rdata = '0; e.chk_data = 1'b0;
    if (mis && !c[2]) begin
      e.kind = 2; e.cond = m_cond; e.req = "R7";
    end else begin
      trap_now = (st ? m_full[addr] : !m_full[addr]) && !c[1];
      m_cond = m_full[addr];
      e.cond = m_cond;
      if (trap_now) begin
        e.kind = 1; e.req = "R3";
      end else begin
        e.kind = 0;
        if (st) begin
          m_data[addr] = wd; e.req = "R5";
          if (c[0]) m_full[addr] = 1'b1;
        end else begin
          e.rdata = m_data[addr]; e.chk_data = 1'b1; e.req = "R4";
          if (c[0]) m_full[addr] = 1'b0;
        end
      end
    end
    sb.push_back(e);
    req_valid = 1'b1; req_store = st; req_code = c;
    req_addr = AW'(addr); req_wdata = wd; miss = mis;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; miss = 1'b0;
    if (mis && c[2]) begin
      for (int i = 0; i < delay; i++) begin
        check(hold == 1'b1, "R8", "hold during stall", hold, 1);
        check(req_ready == 1'b0, "R8", "ready during stall", req_ready, 0);
        @(negedge clk);
      end
      fill_done = 1'b1;
      @(negedge clk);
      fill_done = 1'b0;
      check(hold == 1'b0, "R8", "hold after fill", hold, 0);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(1'b0, "R10", "watchdog", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_full[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    check(hold == 1'b0, "R1", "hold", hold, 0);
    check({rsp_valid, trap_sync, trap_miss} == 3'b000, "R1", "outcomes",
          {rsp_valid, trap_sync, trap_miss}, 0);
    check(cond_full == 1'b0, "R1", "cond_full", cond_full, 0);

    // R2/R3/R4/R5/R6 directed sequence on one word
    access(0, 1, 2, '0, 0, 0);             // trapping load of empty: R3
    access(1, 3, 2, 32'hA5A5_0001, 0, 0);  // plain store, bit stays empty: R5
    access(0, 3, 2, '0, 0, 0);             // non-trapping load of empty: R4
    access(1, 2, 2, 32'hB00B_0002, 0, 0);  // trapping store that fills: R5
    access(1, 1, 2, 32'hDEAD_0003, 0, 0);  // store into full traps: R3
    access(0, 3, 2, '0, 0, 0);             // data unchanged after trap: R3
    access(0, 2, 2, '0, 0, 0);             // load that empties: R4
    access(0, 1, 2, '0, 0, 0);             // now empty again: R3

    // R7 miss trap leaves word alone
    access(1, 4, 5, 32'h1234_5678, 1, 0);
    access(0, 3, 5, '0, 0, 0);

    // R8 stalls
    access(1, 6, 5, 32'hC0DE_0004, 1, 3);  // fill then store that fills
    access(0, 7, 5, '0, 1, 2);             // fill then plain load
    access(1, 6, 5, 32'hBAD0_0005, 1, 1);  // fill then sync trap on full
    access(0, 3, 5, '0, 0, 0);

    // R9 back-to-back on one word, then every code both directions (R2)
    access(1, 4, 7, 32'h7777_0007, 0, 0);
    access(0, 4, 7, '0, 0, 0);
    access(0, 1, 7, '0, 0, 0);
    for (int code = 1; code <= 8; code++) begin
      access(1, code, 8 + (code % 8), DW'(32'h100 + code), 0, 0);
      access(0, code, 8 + (code % 8), '0, 0, 0);
      access(1, code, 8 + ((code + 1) % 8), DW'(32'h200 + code), 0, 0);
    end

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R10", "pending expectations", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule